// File: doc/BRIEF.md
# Frame Timestamp Capture Unit

This block sits beside a free-running symbol counter and a packet receiver. It records the counter value at the moments that matter for frame timing. When the receiver reports a start-of-frame delimiter and timestamping is enabled, the block takes a provisional sample of the count. That sample becomes the committed frame timestamp only after the receiver delivers a frame length byte that is not zero. A length of zero drops the sample, and the earlier committed value stays in place.

The second register is the beacon timestamp. At the end of a frame it takes a copy of the committed frame timestamp, but only when all of these hold: stamping is enabled, the frame is a beacon, its check sequence is good, and the frame is addressed to this network. A frame is addressed to this network when its source network ID equals the local ID, or when the local ID is all ones. Software can also ask for a capture at any time. A one-cycle write sets a self-clearing request bit, and on the next edge the live count goes straight into the beacon register. Software reads the frame timestamp a byte at a time. Reading byte 0 freezes all four bytes so that the upper bytes read afterwards belong to the same value. The block raises no interrupt.

Top module: `ts_capture_top`

## Requirements
- R1: While `rst` is high at a clock edge, `sfd_ts_o`, `bcn_ts_o` and `manual_pend_o` become 0.
- R2: A cycle with `sfd_det_i` and `stamp_en_i` both high stores `count_i` as a provisional sample and arms it. A delimiter pulse with `stamp_en_i` low stores nothing and arms nothing.
- R3: A cycle with `len_valid_i` high while a sample is armed, and with `len_byte_i` not zero, loads the sample into `sfd_ts_o` at that edge. Any `len_valid_i` cycle disarms the sample. If `sfd_det_i` is also high in that cycle, the newly taken sample is the one left armed.
- R4: A length byte of zero, or a length byte with no sample armed, leaves `sfd_ts_o` unchanged. `sfd_ts_o` changes only through R3 or reset.
- R5: A cycle with `frame_end_i`, `stamp_en_i`, `is_beacon_i` and `fcs_ok_i` all high, and with the network condition of R6 met, loads the current `sfd_ts_o` into `bcn_ts_o` at that edge.
- R6: The network condition holds when `src_pan_i == local_pan_i`, or when `local_pan_i == 16'hFFFF`. Otherwise the frame-end copy does not happen.
- R7: `manual_wr_i` high at an edge sets `manual_pend_o` for the next cycle. At the edge that ends that cycle, `bcn_ts_o` takes the `count_i` of that cycle, and `manual_pend_o` clears unless a new write arrives. If the R5 condition holds in the same cycle, the manual capture wins.
- R8: With `rd_sel_i` = 0, `rd_data_o` shows `sfd_ts_o[7:0]`. When `rd_en_i` is also high, the snapshot takes all 32 bits of `sfd_ts_o` at that edge. With `rd_sel_i` = k (1 to 3), `rd_data_o` shows bits [8k+7:8k] of the snapshot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| count_i | input | 32 | Running symbol counter value |
| stamp_en_i | input | 1 | Timestamping enable control bit |
| sfd_det_i | input | 1 | Delimiter-detected pulse |
| len_valid_i | input | 1 | Frame length byte strobe |
| len_byte_i | input | 8 | Received frame length byte |
| frame_end_i | input | 1 | End-of-frame pulse |
| is_beacon_i | input | 1 | Frame type is beacon |
| fcs_ok_i | input | 1 | Frame check sequence valid |
| src_pan_i | input | 16 | Source network ID of the frame |
| local_pan_i | input | 16 | Local network ID register |
| manual_wr_i | input | 1 | Write of 1 to the manual capture bit |
| manual_pend_o | output | 1 | Manual capture bit, self-clearing |
| sfd_ts_o | output | 32 | Committed frame timestamp |
| bcn_ts_o | output | 32 | Beacon timestamp |
| rd_en_i | input | 1 | Byte read strobe |
| rd_sel_i | input | 2 | Byte index for reads (0 = low byte) |
| rd_data_o | output | 8 | Read data byte |

## Verification
Two situations are hard to reach from the ports. The first is a manual capture whose request cycle falls on a qualifying beacon frame end. The second is the frame timestamp being committed again between a low-byte read and the upper-byte reads. Both need several independent strobes to line up in one cycle. The stimulus is random, with each strobe driven at a high rate. The network ID is biased toward a match or toward the all-ones local ID, so that frame ends often qualify and collisions with manual writes and reads happen often. A behavioural model in the bench is compared with every output on every cycle.

// File: rtl/ts_pkg.sv
package ts_pkg;
    localparam int PAN_W = 16;

    typedef struct packed {
        logic             is_beacon;
        logic             fcs_ok;
        logic [PAN_W-1:0] src_pan;
    } frame_info_t;

    typedef enum logic [1:0] {
        BCN_HOLD   = 2'd0,
        BCN_MANUAL = 2'd1,
        BCN_FRAME  = 2'd2
    } bcn_src_e;

    function automatic logic pan_accept(input logic [PAN_W-1:0] src,
                                        input logic [PAN_W-1:0] loc);
        return (loc == {PAN_W{1'b1}}) || (src == loc);
    endfunction
endpackage

// File: rtl/ts_sfd_stage.sv
module ts_sfd_stage #(
    parameter int CNT_W = 32,
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             sfd_det,
    input  logic [CNT_W-1:0] count,
    input  logic             len_valid,
    input  logic [LEN_W-1:0] len_byte,
    output logic [CNT_W-1:0] sfd_ts
);
    logic [CNT_W-1:0] prov_q;
    logic             armed_q;
    logic             commit;

    assign commit = len_valid && armed_q && (len_byte != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            prov_q  <= '0;
            armed_q <= 1'b0;
            sfd_ts  <= '0;
        end else begin
            if (commit)
                sfd_ts <= prov_q;
            if (sfd_det && en) begin
                prov_q  <= count;
                armed_q <= 1'b1;
            end else if (len_valid) begin
                armed_q <= 1'b0;
            end
        end
    end

    // R4
    sfd_change_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(sfd_ts) |-> $past(len_valid && (len_byte != '0)));

    // R2
    arm_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (sfd_det && !en && !armed_q) |=> !armed_q);
endmodule

// File: rtl/ts_beacon_stage.sv
module ts_beacon_stage
    import ts_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             frame_end,
    input  frame_info_t      info,
    input  logic [PAN_W-1:0] local_pan,
    input  logic             manual_wr,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] sfd_ts,
    output logic [CNT_W-1:0] bcn_ts,
    output logic             manual_pend
);
    bcn_src_e sel;
    logic     qualify;

    assign qualify = frame_end && en && info.is_beacon && info.fcs_ok
                     && pan_accept(info.src_pan, local_pan);

    always_comb begin
        if (manual_pend)  sel = BCN_MANUAL;
        else if (qualify) sel = BCN_FRAME;
        else              sel = BCN_HOLD;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bcn_ts      <= '0;
            manual_pend <= 1'b0;
        end else begin
            manual_pend <= manual_wr;
            case (sel)
                BCN_MANUAL: bcn_ts <= count;
                BCN_FRAME:  bcn_ts <= sfd_ts;
                default:    bcn_ts <= bcn_ts;
            endcase
        end
    end

    // R7
    manual_value_chk: assert property (@(posedge clk) disable iff (rst)
        manual_pend |=> (bcn_ts == $past(count)));

    // R7
    manual_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (manual_pend && !manual_wr) |=> !manual_pend);

    // R5
    bcn_cause_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(bcn_ts) |-> $past(manual_pend || frame_end));
endmodule

// File: rtl/ts_read_port.sv
module ts_read_port #(
    parameter int CNT_W  = 32,
    parameter int BYTE_W = 8
) (
    input  logic                                  clk,
    input  logic                                  rst,
    input  logic                                  rd_en,
    input  logic [$clog2(CNT_W/BYTE_W)-1:0]       rd_sel,
    input  logic [CNT_W-1:0]                      sfd_ts,
    output logic [BYTE_W-1:0]                     rd_data
);
    localparam int NBYTES = CNT_W / BYTE_W;

    logic [CNT_W-1:0]  snap_q;
    logic [BYTE_W-1:0] lanes [NBYTES];

    always_ff @(posedge clk) begin
        if (rst)
            snap_q <= '0;
        else if (rd_en && (rd_sel == '0))
            snap_q <= sfd_ts;
    end

    for (genvar g = 0; g < NBYTES; g++) begin : g_lane
        if (g == 0) begin : g_live
            assign lanes[g] = sfd_ts[BYTE_W-1:0];
        end else begin : g_snap
            assign lanes[g] = snap_q[g*BYTE_W +: BYTE_W];
        end
    end

    assign rd_data = lanes[rd_sel];

    // R8
    snap_take_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && (rd_sel == '0)) |=> (snap_q == $past(sfd_ts)));

    // R8
    snap_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(rd_en && (rd_sel == '0)) |=> $stable(snap_q));
endmodule

// File: rtl/ts_capture_top.sv
module ts_capture_top
    import ts_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [31:0] count_i,
    input  logic        stamp_en_i,
    input  logic        sfd_det_i,
    input  logic        len_valid_i,
    input  logic [7:0]  len_byte_i,
    input  logic        frame_end_i,
    input  logic        is_beacon_i,
    input  logic        fcs_ok_i,
    input  logic [15:0] src_pan_i,
    input  logic [15:0] local_pan_i,
    input  logic        manual_wr_i,
    output logic        manual_pend_o,
    output logic [31:0] sfd_ts_o,
    output logic [31:0] bcn_ts_o,
    input  logic        rd_en_i,
    input  logic [1:0]  rd_sel_i,
    output logic [7:0]  rd_data_o
);
    localparam int CNT_W  = 32;
    localparam int LEN_W  = 8;
    localparam int BYTE_W = 8;

    frame_info_t info;
    assign info = '{is_beacon: is_beacon_i, fcs_ok: fcs_ok_i, src_pan: src_pan_i};

    ts_sfd_stage #(.CNT_W(CNT_W), .LEN_W(LEN_W)) u_sfd (
        .clk       (clk),
        .rst       (rst),
        .en        (stamp_en_i),
        .sfd_det   (sfd_det_i),
        .count     (count_i),
        .len_valid (len_valid_i),
        .len_byte  (len_byte_i),
        .sfd_ts    (sfd_ts_o)
    );

    ts_beacon_stage #(.CNT_W(CNT_W)) u_bcn (
        .clk         (clk),
        .rst         (rst),
        .en          (stamp_en_i),
        .frame_end   (frame_end_i),
        .info        (info),
        .local_pan   (local_pan_i),
        .manual_wr   (manual_wr_i),
        .count       (count_i),
        .sfd_ts      (sfd_ts_o),
        .bcn_ts      (bcn_ts_o),
        .manual_pend (manual_pend_o)
    );

    ts_read_port #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_rd (
        .clk     (clk),
        .rst     (rst),
        .rd_en   (rd_en_i),
        .rd_sel  (rd_sel_i),
        .sfd_ts  (sfd_ts_o),
        .rd_data (rd_data_o)
    );

    // R6
    pan_reject_chk: assert property (@(posedge clk) disable iff (rst)
        (!manual_pend_o && frame_end_i && (src_pan_i != local_pan_i)
         && (local_pan_i != 16'hFFFF)) |=> $stable(bcn_ts_o));

    // R1
    reset_state_chk: assert property (@(posedge clk)
        $past(rst) |-> (sfd_ts_o == '0 && bcn_ts_o == '0 && !manual_pend_o));
endmodule

// File: tb/ts_capture_top_tb.sv
module ts_capture_top_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] count_i;
    logic        stamp_en_i, sfd_det_i, len_valid_i, frame_end_i;
    logic [7:0]  len_byte_i;
    logic        is_beacon_i, fcs_ok_i, manual_wr_i, rd_en_i;
    logic [15:0] src_pan_i, local_pan_i;
    logic [1:0]  rd_sel_i;
    logic        manual_pend_o;
    logic [31:0] sfd_ts_o, bcn_ts_o;
    logic [7:0]  rd_data_o;

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    // reference model state
    logic [31:0] m_prov, m_sfd, m_bcn, m_snap;
    logic        m_armed, m_pend;

    always #2 clk = ~clk;

    ts_capture_top u_dut (
        .clk(clk), .rst(rst), .count_i(count_i), .stamp_en_i(stamp_en_i),
        .sfd_det_i(sfd_det_i), .len_valid_i(len_valid_i), .len_byte_i(len_byte_i),
        .frame_end_i(frame_end_i), .is_beacon_i(is_beacon_i), .fcs_ok_i(fcs_ok_i),
        .src_pan_i(src_pan_i), .local_pan_i(local_pan_i), .manual_wr_i(manual_wr_i),
        .manual_pend_o(manual_pend_o), .sfd_ts_o(sfd_ts_o), .bcn_ts_o(bcn_ts_o),
        .rd_en_i(rd_en_i), .rd_sel_i(rd_sel_i), .rd_data_o(rd_data_o)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        sfd_det_i = 0; len_valid_i = 0; len_byte_i = 0; frame_end_i = 0;
        is_beacon_i = 0; fcs_ok_i = 0; manual_wr_i = 0; rd_en_i = 0; rd_sel_i = 0;
    endtask

    // apply one clock edge worth of behaviour to the model (inputs held across it)
    task automatic model_step();
        logic [31:0] o_prov, o_sfd;
        logic        o_armed, o_pend, ok_pan, qual;
        o_prov = m_prov; o_sfd = m_sfd; o_armed = m_armed; o_pend = m_pend;
        if (rst) begin
            m_prov = 0; m_sfd = 0; m_bcn = 0; m_snap = 0; m_armed = 0; m_pend = 0;
            return;
        end
        if (len_valid_i && o_armed && len_byte_i != 0) m_sfd = o_prov;
        if (sfd_det_i && stamp_en_i) begin
            m_prov = count_i; m_armed = 1;
        end else if (len_valid_i) m_armed = 0;
        ok_pan = (src_pan_i == local_pan_i) || (local_pan_i == 16'hFFFF);
        qual = frame_end_i && stamp_en_i && is_beacon_i && fcs_ok_i && ok_pan;
        if (o_pend) m_bcn = count_i;
        else if (qual) m_bcn = o_sfd;
        m_pend = manual_wr_i;
        if (rd_en_i && rd_sel_i == 0) m_snap = o_sfd;
    endtask

    task automatic compare_all();
        logic [7:0] exp_rd;
        exp_rd = (rd_sel_i == 0) ? m_sfd[7:0] : m_snap[rd_sel_i*8 +: 8];
        check("R3", "sfd_ts", sfd_ts_o, m_sfd);
        check("R5", "bcn_ts", bcn_ts_o, m_bcn);
        check("R7", "manual_pend", {31'b0, manual_pend_o}, {31'b0, m_pend});
        check("R8", "rd_data", {24'b0, rd_data_o}, {24'b0, exp_rd});
    endtask

    // one cycle: edge, then model, compare, count advances
    task automatic step();
        @(posedge clk);
        @(negedge clk);
        model_step();
        compare_all();
        count_i = count_i + 1;
    endtask

    initial begin
        #400000;
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        count_i = 32'h1000_0000; stamp_en_i = 1; src_pan_i = 16'h1234;
        local_pan_i = 16'h1234; idle_inputs();
        rst = 1;
        m_prov = 'x; m_sfd = 'x; m_bcn = 'x; m_snap = 'x; m_armed = 0; m_pend = 0;
        step(); step();
        // R1 reset state
        check("R1", "sfd_ts reset", sfd_ts_o, 0);
        check("R1", "bcn_ts reset", bcn_ts_o, 0);
        check("R1", "pend reset", {31'b0, manual_pend_o}, 0);
        rst = 0;

        // R2 R3: enabled delimiter then nonzero length commits
        sfd_det_i = 1; step(); idle_inputs();
        step();
        len_valid_i = 1; len_byte_i = 8'd20; step(); idle_inputs();
        check("R3", "commit value", sfd_ts_o, 32'h1000_0002);

        // R2: disabled delimiter arms nothing
        stamp_en_i = 0; sfd_det_i = 1; step(); idle_inputs(); stamp_en_i = 1;
        len_valid_i = 1; len_byte_i = 8'd9; step(); idle_inputs();
        check("R2", "no capture when disabled", sfd_ts_o, 32'h1000_0002);

        // R4: zero length discards
        sfd_det_i = 1; step(); idle_inputs();
        len_valid_i = 1; len_byte_i = 0; step(); idle_inputs();
        check("R4", "zero length keeps", sfd_ts_o, 32'h1000_0002);

        // R5 R6: qualifying beacon via all-ones local id
        local_pan_i = 16'hFFFF; src_pan_i = 16'h0042;
        frame_end_i = 1; is_beacon_i = 1; fcs_ok_i = 1; step(); idle_inputs();
        check("R6", "broadcast local id copies", bcn_ts_o, 32'h1000_0002);

        // R6: mismatch rejected
        local_pan_i = 16'h0001; manual_wr_i = 1; step(); idle_inputs(); step();
        frame_end_i = 1; is_beacon_i = 1; fcs_ok_i = 1; step(); idle_inputs();
        check("R6", "mismatch rejected", bcn_ts_o, m_bcn);

        // R7: manual wins over qualifying frame end in its capture cycle
        local_pan_i = src_pan_i;
        manual_wr_i = 1; step(); idle_inputs();
        check("R7", "pend set", {31'b0, manual_pend_o}, 1);
        frame_end_i = 1; is_beacon_i = 1; fcs_ok_i = 1; step(); idle_inputs();
        check("R7", "manual priority", bcn_ts_o, count_i - 1);

        // R8: snapshot coherence across a new commit
        rd_en_i = 1; rd_sel_i = 0; step(); idle_inputs();
        sfd_det_i = 1; step(); idle_inputs();
        len_valid_i = 1; len_byte_i = 8'd3; step(); idle_inputs();
        rd_en_i = 1; rd_sel_i = 2; step(); idle_inputs();

        // random phase covering all requirements
        for (int i = 0; i < 4000; i++) begin
            stamp_en_i  = ($urandom_range(0, 7) != 0);
            sfd_det_i   = ($urandom_range(0, 3) == 0);
            len_valid_i = ($urandom_range(0, 3) == 0);
            len_byte_i  = ($urandom_range(0, 3) == 0) ? 8'd0 : 8'($urandom_range(1, 127));
            frame_end_i = ($urandom_range(0, 2) == 0);
            is_beacon_i = ($urandom_range(0, 3) != 0);
            fcs_ok_i    = ($urandom_range(0, 3) != 0);
            case ($urandom_range(0, 2))
                0: local_pan_i = 16'hFFFF;
                1: local_pan_i = src_pan_i;
                default: local_pan_i = 16'($urandom);
            endcase
            src_pan_i   = ($urandom_range(0, 1) == 0) ? local_pan_i : 16'($urandom);
            manual_wr_i = ($urandom_range(0, 5) == 0);
            rd_en_i     = ($urandom_range(0, 1) == 0);
            rd_sel_i    = 2'($urandom_range(0, 3));
            step();
        end
        idle_inputs();
        step();

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule